// File: doc/BRIEF.md
# Per-Process Bank-Zero Address Remapper

This unit sits between the address bus of a 16-bit processor with 24-bit addressing and the main memory. It gives every user program its own private bank zero, which holds that program's stack and direct page. A 24-bit CPU address is split into an 8-bit bank byte and a 16-bit offset. While the unit is in user mode, any access whose bank byte is $00 gets a new bank byte. That byte is read from a map memory indexed by the current program number together with the bank byte. Accesses to any other bank, and every access made in kernel mode, leave the unit unchanged.

Kernel mode is entered in hardware whenever the processor's active-low vector-pull signal is asserted. It is left only when kernel software writes an exit command to a small command register. The same register loads the current program number. The map memory is filled through a separate write port. That port, like the command register, responds only in kernel mode. The translated address appears one clock after the CPU address, together with a valid strobe. The mode flag is also brought out as `kernel_mode`. It selects which half of a private memory is used: the kernel half when high, the map half when low.

Top module: `bank0_remap`

## Requirements
- R1: `mem_valid` is high exactly one clock after a cycle in which `cpu_valid` is high, and low one clock after a cycle in which it is low.
- R2: The offset `mem_addr[15:0]` equals the `cpu_addr[15:0]` of the previous clock. For a valid access whose bank byte `cpu_addr[23:16]` is not $00, `mem_addr[23:16]` equals that bank byte in every mode.
- R3: In user mode, a valid access with bank byte $00 yields `mem_addr[23:16]` = map entry at index {user program number, 8'h00}. In that index the program number fills the upper PID_W bits and the bank byte fills the lower 8 bits.
- R4: In kernel mode, every access passes through unchanged, bank $00 included.
- R5: An access made while `cpu_vp_n` is low is treated as a kernel access and passes unchanged. `kernel_mode` is high from the next clock on.
- R6: `kernel_mode` falls only after a clock in which `kernel_mode` was high, `reg_wr` was high and `reg_sel` was 1 (exit command). If `cpu_vp_n` is low in that same clock, the flag stays high.
- R7: A `reg_wr` with `reg_sel` = 0 in kernel mode loads `user_pid` from `reg_wdata`. The new number is visible and used for lookups from the next clock. Any `reg_wr` made in user mode changes neither `user_pid` nor `kernel_mode`.
- R8: A `map_wr` in kernel mode stores `map_wdata` at index `map_waddr`, and lookups from the next clock use it. A `map_wr` made in user mode leaves the map unchanged.
- R9: After reset, `kernel_mode` = 1, `user_pid` = 0 and `mem_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | CPU address is valid this cycle |
| cpu_addr | input | 24 | CPU address: bank byte in [23:16], offset in [15:0] |
| cpu_vp_n | input | 1 | Vector pull, active low |
| reg_wr | input | 1 | Command register write strobe |
| reg_sel | input | 1 | 0 = load program number, 1 = exit kernel mode |
| reg_wdata | input | PID_W (3) | Program number to load |
| map_wr | input | 1 | Map memory write strobe |
| map_waddr | input | PID_W+8 (11) | Map index {program, bank} |
| map_wdata | input | 8 | Physical bank byte to store |
| mem_valid | output | 1 | Translated address valid |
| mem_addr | output | 24 | Translated address |
| kernel_mode | output | 1 | Mode flag; also selects the private memory half |
| user_pid | output | PID_W (3) | Current user program number |

## Verification
A wrong mode flag or program number is seen at the ports on the very next bank-zero access. The bank byte comes out either untranslated, or translated through another program's map entry, one clock after the access. A wrong flag also shows at once on `kernel_mode`, and a wrong program number on `user_pid`. A lost or misplaced map write shows up as a wrong bank byte on the first user-mode bank-zero access made by that program. The bench therefore interleaves mode changes, refused writes and accesses, and compares every output on every clock.

// File: rtl/bzr_pkg.sv
package bzr_pkg;
  // Command register selector values
  typedef enum logic {
    SEL_PID  = 1'b0,
    SEL_EXIT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/bzr_mode_ctl.sv
module bzr_mode_ctl #(
  parameter int PID_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vp_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [PID_W-1:0] reg_wdata,
  output logic             kflag,
  output logic [PID_W-1:0] pid
);
  import bzr_pkg::*;

  logic cmd_ok;
  logic exit_req;
  logic pid_load;

  assign cmd_ok   = reg_wr & kflag;
  assign exit_req = cmd_ok & (reg_sel == SEL_EXIT);
  assign pid_load = cmd_ok & (reg_sel == SEL_PID);

  // Vector pull has priority over the exit command
  always_ff @(posedge clk) begin
    if (rst) begin
      kflag <= 1'b1;
    end else if (!vp_n) begin
      kflag <= 1'b1;
    end else if (exit_req) begin
      kflag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pid <= '0;
    end else if (pid_load) begin
      pid <= reg_wdata;
    end
  end
endmodule

// File: rtl/bzr_map_ram.sv
module bzr_map_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/bzr_addr_path.sv
module bzr_addr_path #(
  parameter int BANK_W = 8,
  parameter int OFS_W  = 16,
  localparam int AW    = BANK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic [AW-1:0]     cpu_addr,
  input  logic              eff_kernel,
  input  logic [BANK_W-1:0] map_q,
  output logic              mem_valid,
  output logic [AW-1:0]     mem_addr
);
  logic              v_q;
  logic              remap_q;
  logic [BANK_W-1:0] bank_q;
  logic [OFS_W-1:0]  ofs_q;
  logic              hit_zero;

  assign hit_zero = (cpu_addr[AW-1:OFS_W] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q     <= 1'b0;
      remap_q <= 1'b0;
    end else begin
      v_q     <= cpu_valid;
      remap_q <= cpu_valid & ~eff_kernel & hit_zero;
    end
  end

  always_ff @(posedge clk) begin
    if (cpu_valid) begin
      bank_q <= cpu_addr[AW-1:OFS_W];
      ofs_q  <= cpu_addr[OFS_W-1:0];
    end
  end

  assign mem_valid = v_q;
  assign mem_addr  = {(remap_q ? map_q : bank_q), ofs_q};
endmodule

// File: rtl/bank0_remap.sv
module bank0_remap #(
  parameter int PID_W  = 3,
  parameter int BANK_W = 8,
  parameter int OFS_W  = 16,
  localparam int AW    = BANK_W + OFS_W,
  localparam int MAP_AW = PID_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic [AW-1:0]     cpu_addr,
  input  logic              cpu_vp_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [PID_W-1:0]  reg_wdata,
  input  logic              map_wr,
  input  logic [MAP_AW-1:0] map_waddr,
  input  logic [BANK_W-1:0] map_wdata,
  output logic              mem_valid,
  output logic [AW-1:0]     mem_addr,
  output logic              kernel_mode,
  output logic [PID_W-1:0]  user_pid
);
  logic              kflag;
  logic [PID_W-1:0]  pid;
  logic              eff_kernel;
  logic [MAP_AW-1:0] map_raddr;
  logic [BANK_W-1:0] map_q;

  bzr_mode_ctl #(.PID_W(PID_W)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .vp_n      (cpu_vp_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .kflag     (kflag),
    .pid       (pid)
  );

  // Only the bank-zero entry of the current program is ever consulted
  assign map_raddr = {pid, {BANK_W{1'b0}}};

  bzr_map_ram #(.AW(MAP_AW), .DW(BANK_W)) u_map (
    .clk   (clk),
    .we    (map_wr & kflag),
    .waddr (map_waddr),
    .wdata (map_wdata),
    .raddr (map_raddr),
    .rdata (map_q)
  );

  // A vector fetch must reach the real bank zero
  assign eff_kernel = kflag | ~cpu_vp_n;

  bzr_addr_path #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_path (
    .clk        (clk),
    .rst        (rst),
    .cpu_valid  (cpu_valid),
    .cpu_addr   (cpu_addr),
    .eff_kernel (eff_kernel),
    .map_q      (map_q),
    .mem_valid  (mem_valid),
    .mem_addr   (mem_addr)
  );

  assign kernel_mode = kflag;
  assign user_pid    = pid;
endmodule

// File: rtl/bzr_checker.sv
module bzr_checker #(
  parameter int PID_W  = 3,
  parameter int BANK_W = 8,
  parameter int OFS_W  = 16,
  localparam int AW    = BANK_W + OFS_W
) (
  input logic             clk,
  input logic             rst,
  input logic             cpu_valid,
  input logic [AW-1:0]    cpu_addr,
  input logic             cpu_vp_n,
  input logic             reg_wr,
  input logic             reg_sel,
  input logic             mem_valid,
  input logic [AW-1:0]    mem_addr,
  input logic             kernel_mode,
  input logic [PID_W-1:0] user_pid
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    cpu_valid |=> mem_valid);

  a_r1_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !cpu_valid |=> !mem_valid);

  a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
    cpu_valid |=> mem_addr[OFS_W-1:0] == $past(cpu_addr[OFS_W-1:0]));

  a_r2_other_bank_pass: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_addr[AW-1:OFS_W] != '0)
      |=> mem_addr[AW-1:OFS_W] == $past(cpu_addr[AW-1:OFS_W]));

  a_r4_kernel_pass: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && kernel_mode)
      |=> mem_addr[AW-1:OFS_W] == $past(cpu_addr[AW-1:OFS_W]));

  a_r5_vp_pass: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && !cpu_vp_n)
      |=> mem_addr[AW-1:OFS_W] == $past(cpu_addr[AW-1:OFS_W]));

  a_r5_vp_sets_kernel: assert property (@(posedge clk) disable iff (rst)
    !cpu_vp_n |=> kernel_mode);

  a_r6_exit_only_by_cmd: assert property (@(posedge clk) disable iff (rst)
    (kernel_mode && !(reg_wr && reg_sel)) |=> kernel_mode);

  a_r7_pid_held_in_user: assert property (@(posedge clk) disable iff (rst)
    !kernel_mode |=> $stable(user_pid));
endmodule

bind bank0_remap bzr_checker #(.PID_W(PID_W), .BANK_W(BANK_W), .OFS_W(OFS_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cpu_valid   (cpu_valid),
  .cpu_addr    (cpu_addr),
  .cpu_vp_n    (cpu_vp_n),
  .reg_wr      (reg_wr),
  .reg_sel     (reg_sel),
  .mem_valid   (mem_valid),
  .mem_addr    (mem_addr),
  .kernel_mode (kernel_mode),
  .user_pid    (user_pid)
);

// File: tb/bank0_remap_tb.sv
`timescale 1ns/1ps
module bank0_remap_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_valid;
  logic [23:0] cpu_addr;
  logic        cpu_vp_n;
  logic        reg_wr;
  logic        reg_sel;
  logic [2:0]  reg_wdata;
  logic        map_wr;
  logic [10:0] map_waddr;
  logic [7:0]  map_wdata;
  logic        mem_valid;
  logic [23:0] mem_addr;
  logic        kernel_mode;
  logic [2:0]  user_pid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Reference model state
  bit         m_k   = 1'b1;
  int         m_pid = 0;
  logic [7:0] m_map [int];

  always #2 clk = ~clk;

  bank0_remap u_dut (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
    .cpu_vp_n(cpu_vp_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .map_wr(map_wr), .map_waddr(map_waddr),
    .map_wdata(map_wdata), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .kernel_mode(kernel_mode), .user_pid(user_pid)
  );

  task automatic check(input string tag, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One clock: drive at negedge, model the edge, compare at next negedge
  task automatic cyc(input string tag, input logic v, input logic [23:0] a,
                     input logic vpn, input logic rw, input logic rs,
                     input logic [2:0] rd, input logic mw,
                     input logic [10:0] ma, input logic [7:0] md);
    logic [23:0] e_addr;
    bit nk;
    cpu_valid = v; cpu_addr = a; cpu_vp_n = vpn;
    reg_wr = rw; reg_sel = rs; reg_wdata = rd;
    map_wr = mw; map_waddr = ma; map_wdata = md;
    e_addr = a;
    if (v && !(m_k || !vpn) && a[23:16] == 8'h00)
      e_addr[23:16] = m_map.exists(m_pid * 256) ? m_map[m_pid * 256] : 8'hxx;
    nk = m_k;
    if (mw && m_k) m_map[int'(ma)] = md;
    if (rw && m_k && !rs) m_pid = int'(rd);
    if (rw && m_k && rs) nk = 1'b0;
    if (!vpn) nk = 1'b1;
    m_k = nk;
    @(posedge clk);
    @(negedge clk);
    check(tag, "mem_valid", {23'd0, mem_valid}, {23'd0, v});
    if (v) check(tag, "mem_addr", mem_addr, e_addr);
    check(tag, "kernel_mode", {23'd0, kernel_mode}, {23'd0, m_k});
    check(tag, "user_pid", {21'd0, user_pid}, 24'(m_pid));
  endtask

  task automatic acc(input string tag, input logic [23:0] a);
    cyc(tag, 1'b1, a, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 11'd0, 8'd0);
  endtask
  task automatic acc_vp(input string tag, input logic [23:0] a);
    cyc(tag, 1'b1, a, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 11'd0, 8'd0);
  endtask
  task automatic idle(input string tag);
    cyc(tag, 1'b0, 24'h0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 11'd0, 8'd0);
  endtask
  task automatic setpid(input string tag, input logic [2:0] p);
    cyc(tag, 1'b0, 24'h0, 1'b1, 1'b1, 1'b0, p, 1'b0, 11'd0, 8'd0);
  endtask
  task automatic leave(input string tag);
    cyc(tag, 1'b0, 24'h0, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0, 11'd0, 8'd0);
  endtask
  task automatic mapw(input string tag, input logic [2:0] p,
                      input logic [7:0] b, input logic [7:0] d);
    cyc(tag, 1'b0, 24'h0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, {p, b}, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cpu_valid = 0; cpu_addr = 0; cpu_vp_n = 1; reg_wr = 0;
    reg_sel = 0; reg_wdata = 0; map_wr = 0; map_waddr = 0; map_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check("R9", "kernel_mode", {23'd0, kernel_mode}, 24'd1);
    check("R9", "user_pid", {21'd0, user_pid}, 24'd0);
    check("R9", "mem_valid", {23'd0, mem_valid}, 24'd0);

    // R8 fill map in kernel mode
    mapw("R8", 3'd7, 8'h00, 8'h02);
    mapw("R8", 3'd6, 8'h00, 8'h04);
    mapw("R8", 3'd1, 8'h00, 8'h55);
    mapw("R8", 3'd0, 8'h00, 8'h10);
    mapw("R8", 3'd7, 8'h01, 8'h99);
    // R4 kernel passes bank zero and others
    acc("R4", 24'h00_801B);
    acc("R4", 24'h3C_0042);
    // R7 load program 7, R6 leave kernel
    setpid("R7", 3'd7);
    leave("R6");
    // R3 program 7 bank zero -> $02
    acc("R3", 24'h00_801B);
    acc("R3", 24'h00_FFFF);
    // R2 other banks pass in user mode, including bank 1 with a map entry
    acc("R2", 24'h01_1234);
    acc("R2", 24'hFF_0000);
    // R1 idle gives no valid
    idle("R1");
    acc("R1", 24'h00_0001);
    // R7 user-mode writes ignored
    setpid("R7", 3'd6);
    leave("R7");
    // R8 user-mode map write ignored
    mapw("R8", 3'd7, 8'h00, 8'hEE);
    acc("R8", 24'h00_801B);
    // R5 vector pull in user mode: passes, then kernel
    acc_vp("R5", 24'h00_FFEA);
    acc("R5", 24'h00_801B);
    // R7 switch to program 6 -> $04
    setpid("R7", 3'd6);
    leave("R6");
    acc("R3", 24'h00_801B);
    // R6 exit and vector pull together keep kernel
    acc_vp("R5", 24'h00_FFEE);
    cyc("R6", 1'b0, 24'h0, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0, 11'd0, 8'd0);
    acc("R6", 24'h00_2000);
    // R8 map write in the clock that exits kernel is used next clock
    setpid("R7", 3'd1);
    cyc("R8", 1'b0, 24'h0, 1'b1, 1'b1, 1'b1, 3'd0, 1'b1, {3'd1, 8'h00}, 8'hA7);
    acc("R8", 24'h00_0100);
    // back-to-back bank zero and other bank
    acc("R3", 24'h00_1111);
    acc("R2", 24'h02_1111);
    // R5 return to kernel, program 0
    acc_vp("R5", 24'h00_FFFC);
    setpid("R7", 3'd0);
    leave("R6");
    acc("R3", 24'h00_ABCD);
    for (int i = 0; i < 8; i++) acc("R2", {8'(i + 1), 16'(i * 4099)});
    idle("R1");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule